// File: doc/BRIEF.md
# Banked Branch Record Buffer

The block keeps a short history of the most recent taken branches. Each branch event arrives with a source address, a target address, a 4-bit class code, an exception level for each endpoint (user or kernel), a mispredict flag and a cycle count. Two filters decide whether the event is kept. The first is a per-class enable mask. The second is a pair of per-level enables. A kept event becomes a record at slot 0, and every older record moves back one slot. When the buffer is full, the oldest record is lost.

Software reads the history through a banked index port. A bank-select register picks a group of 32 records, and a 5-bit index picks one record inside that group. The buffer can be paused. It can freeze itself when an external overflow signal arrives, if freeze is enabled. It can also be wiped in one cycle. A record whose validity code reads as none marks the end of the valid history.

Top module: `brb_buffer`

## Requirements
- R1: A captured event is readable at bank 0, index 0 after the next clock edge. Each older record moves back by one slot. With NUM_REC records held, the oldest record is discarded on capture.
- R2: The info word has this layout: [1:0] validity (0 none, 1 source only, 2 target only, 3 full), [2] mispredict, [6:3] class code, [7] target level (1 = kernel), [8] cycle-unknown flag, [16:9] cycle count.
- R3: A class code c in 0..7 is captured only while type-enable bit c is set. Class codes 8..15 are never captured. Code meanings are 0 direct jump, 1 indirect jump, 2 direct call, 3 indirect call, 4 return, 5 conditional direct, 6 exception entry and 7 exception return.
- R4: An endpoint is kept when the enable for its level is set (user enable for level 0, kernel enable for level 1). A dropped endpoint reads as address zero. One kept endpoint gives validity code 1 or 2. Two kept endpoints give code 3. No kept endpoint means no capture.
- R5: The mispredict bit is recorded only when the source is kept. The level bit holds the target level only when the target is kept. Otherwise each of these bits is 0.
- R6: A 16-bit cycle count saturates to 255 in the 8-bit field. When the count is marked unknown, bit 8 is set and the count field is 0.
- R7: While paused, no event is captured. A pause-set pulse pauses from the next cycle, and a pause-clear pulse resumes. If set and clear arrive together, set wins. The state appears on paused_o.
- R8: With freeze enabled, an overflow pulse pauses the buffer from the next cycle. An event in the overflow cycle itself is still captured. With freeze disabled, overflow has no effect.
- R9: Invalidate-all clears every record in one cycle. If a capture happens in the same cycle, the new record is kept at slot 0 and all other slots become invalid.
- R10: A bank-select value is applied to reads from the cycle after it is presented. The record read is number bank*32+index, counted from the newest.
- R11: A record number at or above NUM_REC reads as all zeros, with validity code none.
- R12: After reset every record reads as zero, the buffer is not paused, and bank 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | Branch event present this cycle |
| br_src | input | AW | Source address |
| br_tgt | input | AW | Target address |
| br_kind | input | 4 | Branch class code |
| br_src_kern | input | 1 | Source is at kernel level |
| br_tgt_kern | input | 1 | Target is at kernel level |
| br_mispred | input | 1 | Branch was mispredicted |
| br_cycles | input | 16 | Cycles since previous branch |
| br_cyc_ok | input | 1 | Cycle count is known |
| cfg_kind_en | input | 8 | Per-class capture enables |
| cfg_user_en | input | 1 | Keep user-level endpoints |
| cfg_kern_en | input | 1 | Keep kernel-level endpoints |
| cfg_freeze_en | input | 1 | Overflow pauses capture |
| overflow_i | input | 1 | External counter overflow pulse |
| pause_set | input | 1 | Pause capture |
| pause_clr | input | 1 | Resume capture |
| inv_all | input | 1 | Invalidate all records |
| bank_sel | input | BANK_W | Bank to read |
| rd_idx | input | 5 | Record index within bank |
| rd_src | output | AW | Source address of selected record |
| rd_tgt | output | AW | Target address of selected record |
| rd_info | output | 17 | Info word of selected record |
| paused_o | output | 1 | Capture is paused |

## Verification
Capture and invalidate-all can both act on the storage in the same cycle. The bench drives a kept branch together with an invalidate pulse. It then expects the new record at slot 0 and validity code none at slot 1. Overflow and capture can also coincide. For that case the bench drives a branch in the overflow cycle and judges it captured, while the next branch must be dropped. Random runs raise both pulses independently, and a model applies invalidate before shift, so any overlap it finds is checked against the same rule.

// File: rtl/brb_pkg.sv
package brb_pkg;
  localparam int CYC_W  = 8;
  localparam int CNT_W  = 16;
  localparam int KIND_W = 4;
  localparam int IDX_W  = 5;
  localparam int BANK_SZ = 32;

  typedef enum logic [1:0] {
    VLD_NONE = 2'd0,
    VLD_SRC  = 2'd1,
    VLD_TGT  = 2'd2,
    VLD_FULL = 2'd3
  } vld_e;

  typedef struct packed {
    logic [CYC_W-1:0]  cyc;
    logic              unk;
    logic              lvl;
    logic [KIND_W-1:0] kind;
    logic              mis;
    vld_e              vld;
  } info_t;

  localparam int INFO_W = $bits(info_t);

  function automatic logic [CYC_W-1:0] sat_cycles(input logic [CNT_W-1:0] c);
    logic [CYC_W-1:0] top;
    top = '1;
    if (c > CNT_W'(top)) return top;
    return c[CYC_W-1:0];
  endfunction

  function automatic vld_e vld_code(input logic s_keep, input logic t_keep);
    case ({t_keep, s_keep})
      2'b01:   return VLD_SRC;
      2'b10:   return VLD_TGT;
      2'b11:   return VLD_FULL;
      default: return VLD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/brb_filter.sv
module brb_filter
  import brb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              br_valid,
  input  logic [AW-1:0]     br_src,
  input  logic [AW-1:0]     br_tgt,
  input  logic [KIND_W-1:0] br_kind,
  input  logic              br_src_kern,
  input  logic              br_tgt_kern,
  input  logic              br_mispred,
  input  logic [CNT_W-1:0]  br_cycles,
  input  logic              br_cyc_ok,
  input  logic [7:0]        cfg_kind_en,
  input  logic              cfg_user_en,
  input  logic              cfg_kern_en,
  output logic              keep,
  output logic [AW-1:0]     new_src,
  output logic [AW-1:0]     new_tgt,
  output info_t             new_info
);
  logic kind_ok, s_keep, t_keep;

  assign kind_ok = !br_kind[KIND_W-1] && cfg_kind_en[br_kind[2:0]];
  assign s_keep  = br_src_kern ? cfg_kern_en : cfg_user_en;
  assign t_keep  = br_tgt_kern ? cfg_kern_en : cfg_user_en;
  assign keep    = br_valid && kind_ok && (s_keep || t_keep);

  always_comb begin
    new_src       = s_keep ? br_src : '0;
    new_tgt       = t_keep ? br_tgt : '0;
    new_info.vld  = vld_code(s_keep, t_keep);
    new_info.mis  = s_keep && br_mispred;
    new_info.lvl  = t_keep && br_tgt_kern;
    new_info.kind = br_kind;
    new_info.unk  = !br_cyc_ok;
    new_info.cyc  = br_cyc_ok ? sat_cycles(br_cycles) : '0;
  end
endmodule

// File: rtl/brb_store.sv
module brb_store
  import brb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NUM_REC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          wipe,
  input  logic [AW-1:0] new_src,
  input  logic [AW-1:0] new_tgt,
  input  info_t         new_info,
  output logic [AW-1:0] src_q  [NUM_REC],
  output logic [AW-1:0] tgt_q  [NUM_REC],
  output info_t         info_q [NUM_REC],
  output vld_e          head_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REC; i++) begin
        src_q[i]  <= '0;
        tgt_q[i]  <= '0;
        info_q[i] <= '0;
      end
    end else if (cap) begin
      src_q[0]  <= new_src;
      tgt_q[0]  <= new_tgt;
      info_q[0] <= new_info;
      for (int i = 1; i < NUM_REC; i++) begin
        src_q[i]  <= wipe ? '0 : src_q[i-1];
        tgt_q[i]  <= wipe ? '0 : tgt_q[i-1];
        info_q[i] <= wipe ? '0 : info_q[i-1];
      end
    end else if (wipe) begin
      for (int i = 0; i < NUM_REC; i++) begin
        src_q[i]  <= '0;
        tgt_q[i]  <= '0;
        info_q[i] <= '0;
      end
    end
  end

  assign head_vld = info_q[0].vld;
endmodule

// File: rtl/brb_readport.sv
module brb_readport
  import brb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NUM_REC = 64,
  parameter int BANK_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [AW-1:0]     src_q  [NUM_REC],
  input  logic [AW-1:0]     tgt_q  [NUM_REC],
  input  info_t             info_q [NUM_REC],
  output logic [BANK_W-1:0] bank_q,
  output logic [AW-1:0]     rd_src,
  output logic [AW-1:0]     rd_tgt,
  output info_t             rd_info
);
  localparam int GW = BANK_W + IDX_W;
  logic [GW-1:0] gidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_sel;
  end

  assign gidx = {bank_q, rd_idx};

  always_comb begin
    rd_src  = '0;
    rd_tgt  = '0;
    rd_info = '0;
    for (int i = 0; i < NUM_REC; i++) begin
      if (gidx == GW'(i)) begin
        rd_src  = src_q[i];
        rd_tgt  = tgt_q[i];
        rd_info = info_q[i];
      end
    end
  end
endmodule

// File: rtl/brb_buffer.sv
module brb_buffer
  import brb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NUM_REC = 64,
  localparam int NBANK  = (NUM_REC + BANK_SZ - 1) / BANK_SZ,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [AW-1:0]     br_src,
  input  logic [AW-1:0]     br_tgt,
  input  logic [3:0]        br_kind,
  input  logic              br_src_kern,
  input  logic              br_tgt_kern,
  input  logic              br_mispred,
  input  logic [15:0]       br_cycles,
  input  logic              br_cyc_ok,
  input  logic [7:0]        cfg_kind_en,
  input  logic              cfg_user_en,
  input  logic              cfg_kern_en,
  input  logic              cfg_freeze_en,
  input  logic              overflow_i,
  input  logic              pause_set,
  input  logic              pause_clr,
  input  logic              inv_all,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [4:0]        rd_idx,
  output logic [AW-1:0]     rd_src,
  output logic [AW-1:0]     rd_tgt,
  output logic [16:0]       rd_info,
  output logic              paused_o
);
  logic          keep, cap_fire, freeze_hit, pause_q;
  logic [AW-1:0] new_src, new_tgt;
  info_t         new_info, rd_info_s;
  vld_e          head_vld;
  logic [BANK_W-1:0] bank_q;
  logic [AW-1:0] src_q  [NUM_REC];
  logic [AW-1:0] tgt_q  [NUM_REC];
  info_t         info_q [NUM_REC];

  brb_filter #(.AW(AW)) u_filter (
    .br_valid(br_valid), .br_src(br_src), .br_tgt(br_tgt), .br_kind(br_kind),
    .br_src_kern(br_src_kern), .br_tgt_kern(br_tgt_kern), .br_mispred(br_mispred),
    .br_cycles(br_cycles), .br_cyc_ok(br_cyc_ok), .cfg_kind_en(cfg_kind_en),
    .cfg_user_en(cfg_user_en), .cfg_kern_en(cfg_kern_en), .keep(keep),
    .new_src(new_src), .new_tgt(new_tgt), .new_info(new_info)
  );

  assign freeze_hit = cfg_freeze_en && overflow_i;
  assign cap_fire   = keep && !pause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pause_q <= 1'b0;
    else if (pause_set || freeze_hit)  pause_q <= 1'b1;
    else if (pause_clr)                pause_q <= 1'b0;
  end
  assign paused_o = pause_q;

  brb_store #(.AW(AW), .NUM_REC(NUM_REC)) u_store (
    .clk(clk), .rst_n(rst_n), .cap(cap_fire), .wipe(inv_all),
    .new_src(new_src), .new_tgt(new_tgt), .new_info(new_info),
    .src_q(src_q), .tgt_q(tgt_q), .info_q(info_q), .head_vld(head_vld)
  );

  brb_readport #(.AW(AW), .NUM_REC(NUM_REC), .BANK_W(BANK_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .rd_idx(rd_idx),
    .src_q(src_q), .tgt_q(tgt_q), .info_q(info_q), .bank_q(bank_q),
    .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_info(rd_info_s)
  );
  assign rd_info = rd_info_s;
endmodule

// File: rtl/brb_buffer_chk.sv
module brb_buffer_chk #(
  parameter int NUM_REC = 64,
  parameter int BANK_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic [3:0]        br_kind,
  input logic [7:0]        cfg_kind_en,
  input logic              cfg_freeze_en,
  input logic              overflow_i,
  input logic              pause_set,
  input logic              pause_clr,
  input logic              inv_all,
  input logic              paused_o,
  input logic              cap_fire,
  input logic [1:0]        head_vld,
  input logic [1:0]        new_vld,
  input logic [1:0]        rd_vld,
  input logic [BANK_W-1:0] bank_q,
  input logic [4:0]        rd_idx
);
  logic rd_oor;
  assign rd_oor = int'({bank_q, rd_idx}) >= NUM_REC;

  AST_PAUSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    paused_o |-> !cap_fire); // R7
  AST_CLEAR_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_clr && !pause_set && !(cfg_freeze_en && overflow_i)) |=> !paused_o); // R7
  AST_FREEZE_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_freeze_en && overflow_i) |=> paused_o); // R8
  AST_KIND_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && (br_kind[3] || !cfg_kind_en[br_kind[2:0]])) |-> !cap_fire); // R3
  AST_HEAD_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> head_vld != 2'd0); // R1
  AST_NEW_HAS_END: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |-> new_vld != 2'd0); // R4
  AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !cap_fire) |=> head_vld == 2'd0); // R9
  AST_OOR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oor |-> rd_vld == 2'd0); // R11
endmodule

bind brb_buffer brb_buffer_chk #(.NUM_REC(NUM_REC), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
  .cfg_kind_en(cfg_kind_en), .cfg_freeze_en(cfg_freeze_en), .overflow_i(overflow_i),
  .pause_set(pause_set), .pause_clr(pause_clr), .inv_all(inv_all), .paused_o(paused_o),
  .cap_fire(cap_fire), .head_vld(head_vld), .new_vld(new_info.vld),
  .rd_vld(rd_info[1:0]), .bank_q(bank_q), .rd_idx(rd_idx)
);

// File: tb/brb_buffer_tb_top.sv
`timescale 1ns/1ps
module brb_buffer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        br_valid = 0, br_src_kern = 0, br_tgt_kern = 0, br_mispred = 0, br_cyc_ok = 1;
  logic [31:0] br_src = 0, br_tgt = 0;
  logic [3:0]  br_kind = 0;
  logic [15:0] br_cycles = 0;
  logic [7:0]  cfg_kind_en = 8'hFF;
  logic        cfg_user_en = 1, cfg_kern_en = 1, cfg_freeze_en = 0;
  logic        overflow_i = 0, pause_set = 0, pause_clr = 0, inv_all = 0;
  logic        bank_sel = 0;
  logic [4:0]  rd_idx = 0;
  logic [31:0] rd_src, rd_tgt, rs16, rt16;
  logic [16:0] rd_info, ri16;
  logic        paused_o, p16;

  brb_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src), .br_tgt(br_tgt),
    .br_kind(br_kind), .br_src_kern(br_src_kern), .br_tgt_kern(br_tgt_kern),
    .br_mispred(br_mispred), .br_cycles(br_cycles), .br_cyc_ok(br_cyc_ok),
    .cfg_kind_en(cfg_kind_en), .cfg_user_en(cfg_user_en), .cfg_kern_en(cfg_kern_en),
    .cfg_freeze_en(cfg_freeze_en), .overflow_i(overflow_i), .pause_set(pause_set),
    .pause_clr(pause_clr), .inv_all(inv_all), .bank_sel(bank_sel), .rd_idx(rd_idx),
    .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_info(rd_info), .paused_o(paused_o)
  );

  brb_buffer #(.NUM_REC(16)) dut16_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src), .br_tgt(br_tgt),
    .br_kind(br_kind), .br_src_kern(br_src_kern), .br_tgt_kern(br_tgt_kern),
    .br_mispred(br_mispred), .br_cycles(br_cycles), .br_cyc_ok(br_cyc_ok),
    .cfg_kind_en(cfg_kind_en), .cfg_user_en(cfg_user_en), .cfg_kern_en(cfg_kern_en),
    .cfg_freeze_en(cfg_freeze_en), .overflow_i(overflow_i), .pause_set(pause_set),
    .pause_clr(pause_clr), .inv_all(inv_all), .bank_sel(bank_sel), .rd_idx(rd_idx),
    .rd_src(rs16), .rd_tgt(rt16), .rd_info(ri16), .paused_o(p16)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_src [64];
  logic [31:0] m_tgt [64];
  logic [16:0] m_inf [64];
  logic        m_pause = 0;
  logic        bank_cur = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected info word, assembled field by field from the requirement text
  function automatic logic [16:0] exp_info(input logic sk, input logic tk);
    int cyc;
    logic [16:0] w;
    cyc = br_cyc_ok ? ((br_cycles > 16'd255) ? 255 : int'(br_cycles)) : 0;
    w = 17'(cyc) << 9;
    w |= 17'(!br_cyc_ok) << 8;
    w |= 17'(tk & br_tgt_kern) << 7;
    w |= 17'(br_kind) << 3;
    w |= 17'(sk & br_mispred) << 2;
    w |= 17'(tk) << 1;
    w |= 17'(sk);
    return w;
  endfunction

  task automatic tick();
    logic sk, tk, take, np;
    sk = br_src_kern ? cfg_kern_en : cfg_user_en;
    tk = br_tgt_kern ? cfg_kern_en : cfg_user_en;
    take = br_valid && !m_pause && (br_kind < 4'd8) && cfg_kind_en[br_kind[2:0]] && (sk || tk);
    np = (pause_set || (cfg_freeze_en && overflow_i)) ? 1'b1 : (pause_clr ? 1'b0 : m_pause);
    @(posedge clk);
    #1;
    if (inv_all)
      for (int i = 0; i < 64; i++) begin m_src[i] = 0; m_tgt[i] = 0; m_inf[i] = 0; end
    if (take) begin
      for (int i = 63; i > 0; i--) begin
        m_src[i] = m_src[i-1]; m_tgt[i] = m_tgt[i-1]; m_inf[i] = m_inf[i-1];
      end
      m_src[0] = sk ? br_src : 0;
      m_tgt[0] = tk ? br_tgt : 0;
      m_inf[0] = exp_info(sk, tk);
    end
    m_pause = np;
    bank_cur = bank_sel;
  endtask

  task automatic check_rd(input string tag);
    int g;
    g = int'(bank_cur) * 32 + int'(rd_idx);
    chk({tag, " src"}, 64'(rd_src), 64'(m_src[g]));
    chk({tag, " tgt"}, 64'(rd_tgt), 64'(m_tgt[g]));
    chk({tag, " info"}, 64'(rd_info), 64'(m_inf[g]));
  endtask

  task automatic check_rd16(input string tag);
    int g;
    g = int'(bank_cur) * 32 + int'(rd_idx);
    chk({tag, " src16"}, 64'(rs16), (g < 16) ? 64'(m_src[g]) : 64'd0);
    chk({tag, " info16"}, 64'(ri16), (g < 16) ? 64'(m_inf[g]) : 64'd0);
  endtask

  task automatic branch(input logic [31:0] s, input logic [31:0] t, input logic [3:0] k);
    br_valid = 1; br_src = s; br_tgt = t; br_kind = k;
    tick();
    br_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin m_src[i] = 0; m_tgt[i] = 0; m_inf[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R12 reset state
    chk("R12 paused", 64'(paused_o), 64'd0);
    rd_idx = 0; #1 check_rd("R12 idx0");
    rd_idx = 31; #1 chk("R12 idx31 info", 64'(rd_info), 64'd0);
    rd_idx = 0;
    // R1 R2 single full record
    br_mispred = 1; br_cycles = 16'd37; br_tgt_kern = 1;
    branch(32'hA000_0010, 32'hB000_0020, 4'd2);
    check_rd("R1 first");
    chk("R2 layout", 64'(rd_info), 64'({8'd37, 1'b0, 1'b1, 4'd2, 1'b1, 2'd3}));
    br_mispred = 0; br_tgt_kern = 0;
    // R1 R10 fill beyond capacity
    for (int i = 0; i < 70; i++) branch(32'h1000 + 32'(i), 32'h2000 + 32'(i), 4'd0);
    rd_idx = 0; #1 check_rd("R1 newest");
    chk("R1 newest src", 64'(rd_src), 64'h1045);
    bank_sel = 1; rd_idx = 31; #1;
    chk("R10 bank not yet applied", 64'(rd_src), 64'(m_src[31]));
    tick();
    check_rd("R10 bank1 last");
    chk("R1 oldest kept", 64'(rd_src), 64'h1006);
    bank_sel = 0; tick(); rd_idx = 0;
    // R3 class mask
    cfg_kind_en = 8'b1101_1111;
    branch(32'h5, 32'h6, 4'd5); #1 check_rd("R3 masked class");
    branch(32'h7, 32'h8, 4'd9); #1 check_rd("R3 code above 7");
    chk("R3 head unchanged", 64'(rd_src), 64'h1045);
    cfg_kind_en = 8'hFF;
    // R4 R5 level enables
    cfg_kern_en = 0; br_mispred = 1;
    br_src_kern = 0; br_tgt_kern = 1; branch(32'h11, 32'h22, 4'd6);
    check_rd("R4 source only");
    chk("R5 mis kept", 64'(rd_info[2]), 64'd1);
    br_src_kern = 1; br_tgt_kern = 0; branch(32'h33, 32'h44, 4'd7);
    check_rd("R4 target only");
    chk("R5 mis dropped", 64'(rd_info[2:0]), 64'd2);
    br_src_kern = 1; br_tgt_kern = 1; branch(32'h55, 32'h66, 4'd1);
    check_rd("R4 both dropped");
    cfg_kern_en = 1; br_mispred = 0; br_src_kern = 0; br_tgt_kern = 0;
    // R6 cycles
    br_cycles = 16'd1000; branch(32'h70, 32'h71, 4'd4);
    check_rd("R6 saturate"); chk("R6 sat field", 64'(rd_info[16:9]), 64'd255);
    br_cyc_ok = 0; branch(32'h72, 32'h73, 4'd4);
    check_rd("R6 unknown"); chk("R6 unk bits", 64'(rd_info[16:8]), 64'h1);
    br_cyc_ok = 1;
    // R7 pause
    pause_set = 1; tick(); pause_set = 0;
    chk("R7 paused", 64'(paused_o), 64'd1);
    branch(32'h80, 32'h81, 4'd0); check_rd("R7 no capture");
    pause_set = 1; pause_clr = 1; tick(); pause_set = 0; pause_clr = 0;
    chk("R7 set wins", 64'(paused_o), 64'd1);
    pause_clr = 1; tick(); pause_clr = 0;
    chk("R7 resumed", 64'(paused_o), 64'd0);
    branch(32'h82, 32'h83, 4'd0); check_rd("R7 capture again");
    // R8 freeze
    overflow_i = 1; branch(32'h90, 32'h91, 4'd0); overflow_i = 0;
    check_rd("R8 ignored overflow"); chk("R8 not paused", 64'(paused_o), 64'd0);
    cfg_freeze_en = 1; overflow_i = 1; branch(32'h92, 32'h93, 4'd0); overflow_i = 0;
    check_rd("R8 same cycle kept"); chk("R8 frozen", 64'(paused_o), 64'd1);
    branch(32'h94, 32'h95, 4'd0); check_rd("R8 dropped after");
    cfg_freeze_en = 0; pause_clr = 1; tick(); pause_clr = 0;
    // R9 invalidate with simultaneous capture
    inv_all = 1; branch(32'hC0, 32'hC1, 4'd3); inv_all = 0;
    check_rd("R9 new kept");
    rd_idx = 1; #1 check_rd("R9 rest cleared"); chk("R9 idx1 vld", 64'(rd_info[1:0]), 64'd0);
    rd_idx = 0; inv_all = 1; tick(); inv_all = 0;
    check_rd("R9 wipe"); chk("R9 head vld", 64'(rd_info[1:0]), 64'd0);
    // R11 out of range on the 16-record instance
    for (int i = 0; i < 20; i++) branch(32'h300 + 32'(i), 32'h400 + 32'(i), 4'd5);
    rd_idx = 15; #1 check_rd16("R11 last in range");
    rd_idx = 16; #1 check_rd16("R11 beyond count");
    bank_sel = 1; tick(); rd_idx = 3; #1 check_rd16("R11 bank beyond");
    // random phase R1 R3 R4 R7 R8 R9 R10
    for (int c = 0; c < 600; c++) begin
      br_valid = $urandom_range(0, 3) != 0;
      br_src = $urandom; br_tgt = $urandom; br_kind = 4'($urandom_range(0, 9));
      br_src_kern = 1'($urandom); br_tgt_kern = 1'($urandom); br_mispred = 1'($urandom);
      br_cycles = 16'($urandom_range(0, 400)); br_cyc_ok = $urandom_range(0, 5) != 0;
      if (c % 50 == 0) begin
        cfg_kind_en = 8'($urandom) | 8'h01; cfg_user_en = 1'($urandom);
        cfg_kern_en = 1'($urandom); cfg_freeze_en = 1'($urandom);
      end
      pause_set = $urandom_range(0, 39) == 0; pause_clr = $urandom_range(0, 7) == 0;
      overflow_i = $urandom_range(0, 49) == 0; inv_all = $urandom_range(0, 59) == 0;
      bank_sel = 1'($urandom); rd_idx = 5'($urandom);
      tick();
      check_rd("R1 random");
      check_rd16("R11 random");
      chk("R7 random pause", 64'(paused_o), 64'(m_pause));
    end
    br_valid = 0; pause_set = 0; pause_clr = 0; overflow_i = 0; inv_all = 0;
    for (int b = 0; b < 2; b++) begin
      bank_sel = 1'(b); tick();
      for (int i = 0; i < 32; i++) begin rd_idx = 5'(i); #1 check_rd("R10 dump"); end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule